// File: doc/BRIEF.md
# Hexadecimal Floating-Point Sign-Control Load Unit

This unit performs the load family of hexadecimal floating-point operations on one operand: a straight copy, a copy that also reports a condition code, and three sign-editing variants. The editing variants flip the sign, force it to plus, or force it to minus. Each operation works on a short 32-bit operand or a long 64-bit operand. The operand has a sign bit, a 7-bit excess-64 exponent field and a hexadecimal fraction. The exponent and fraction are never altered. A zero fraction is not cleaned into a true zero, so the result can be a zero fraction that still carries a nonzero exponent or a minus sign.

The surrounding datapath presents the source word, the current destination word, the operation code and a length flag, with a one-cycle valid strobe. On the next clock edge the unit returns the new destination word and a done pulse. When the operation is one that reports status, it also returns a 2-bit condition code with a write strobe. In short mode only the upper half of the destination is replaced; the lower half comes back from the old destination value unchanged.

Top module: `hfp_signload`

## Requirements
- R1: Word layout is sign at bit 63, exponent at bits 62:56, fraction at bits 55:0 (long) or 55:32 (short). The exponent and fraction bits of the result equal those of the source in every operation, with no true-zero forcing when the fraction is zero.
- R2: With `is_long`=0, result bits 63:32 come from the operation on `src[63:32]` and result bits 31:0 equal `dst_old[31:0]`. `src[31:0]` does not affect any output.
- R3: With `is_long`=1, all 64 result bits come from `src`, and the whole 56-bit fraction feeds the zero test.
- R4: Operation codes are 0 plain load, 1 load-and-test, 2 complement, 3 force positive and 4 force negative. Codes 0 and 1 copy the sign, code 2 inverts it, code 3 clears it and code 4 sets it. Codes 5 to 7 behave as code 0.
- R5: The condition code is 0 when the result fraction is zero, regardless of sign. It is 1 when the fraction is nonzero and the sign is minus, and 2 when the fraction is nonzero and the sign is plus. In short mode only the 24 short fraction bits are tested.
- R6: Codes 1 to 4 raise `cc_we` with `done` and update `cc`. Codes 0 and 5 to 7 keep `cc_we` low and leave `cc` unchanged.
- R7: Force positive yields only code 0 or 2. Force negative yields only code 0 or 1.
- R8: The outputs update on the clock edge that samples `in_valid`=1, and `done` is high for exactly that one cycle. Without `in_valid`, `result` and `cc` hold and `done`/`cc_we` stay low.
- R9: While `rst_n` is low, `result`, `cc`, `done` and `cc_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle request strobe |
| op | input | 3 | Operation code (see R4) |
| is_long | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| src | input | 64 | Source operand |
| dst_old | input | 64 | Current destination contents |
| result | output | 64 | New destination contents |
| cc | output | 2 | Condition code |
| cc_we | output | 1 | Condition code write strobe |
| done | output | 1 | Result valid pulse |

## Verification
The hardest case is a short operand whose 24-bit fraction is zero while the unused low half of the source is nonzero. Here the zero test must ignore those bits, report code 0 and still keep any minus sign and nonzero exponent. The stimulus reaches this case directly by driving such words with nonzero garbage in `src[31:0]` and a distinct pattern in `dst_old`. A plain load placed right after a status-setting operation exposes whether `cc` really holds its earlier value.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
    localparam int CHAR_W    = 7;
    localparam int FRAC_L_W  = 56;
    localparam int FRAC_S_W  = 24;
    localparam int WORD_W    = 1 + CHAR_W + FRAC_L_W;
    localparam int HALF_W    = WORD_W / 2;
    localparam int SIGN_POS  = WORD_W - 1;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_TEST = 3'd1,
        OP_COMP = 3'd2,
        OP_POS  = 3'd3,
        OP_NEG  = 3'd4
    } sgn_op_e;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2
    } cc_e;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic [1:0]        cc;
        logic              cc_we;
        logic              done;
    } sl_state_t;
endpackage

// File: rtl/hfp_sign_edit.sv
module hfp_sign_edit
    import hfp_pkg::*;
(
    input  logic [2:0] op,
    input  logic       sign_in,
    output logic       sign_out,
    output logic       sets_cc
);
    always_comb begin
        sign_out = sign_in;
        sets_cc  = 1'b0;
        case (op)
            OP_TEST: begin sign_out = sign_in;  sets_cc = 1'b1; end
            OP_COMP: begin sign_out = ~sign_in; sets_cc = 1'b1; end
            OP_POS:  begin sign_out = 1'b0;     sets_cc = 1'b1; end
            OP_NEG:  begin sign_out = 1'b1;     sets_cc = 1'b1; end
            default: begin sign_out = sign_in;  sets_cc = 1'b0; end
        endcase
    end
endmodule

// File: rtl/hfp_cc_gen.sv
module hfp_cc_gen
    import hfp_pkg::*;
(
    input  logic                sign,
    input  logic [FRAC_L_W-1:0] frac,
    input  logic                is_long,
    output logic [1:0]          cc
);
    localparam int TAIL_W = FRAC_L_W - FRAC_S_W;

    logic head_nz;
    logic tail_nz;
    logic frac_nz;

    assign head_nz = |frac[FRAC_L_W-1:TAIL_W];
    assign tail_nz = |frac[TAIL_W-1:0];
    assign frac_nz = head_nz | (is_long & tail_nz);

    always_comb begin
        if (!frac_nz)  cc = CC_ZERO;
        else if (sign) cc = CC_NEG;
        else           cc = CC_POS;
    end
endmodule

// File: rtl/hfp_signload.sv
module hfp_signload
    import hfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic              is_long,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] dst_old,
    output logic [WORD_W-1:0] result,
    output logic [1:0]        cc,
    output logic              cc_we,
    output logic              done
);
    localparam int FRAC_TOP = FRAC_L_W - 1;

    sl_state_t st_d, st_q;

    logic       new_sign;
    logic       sets_cc;
    logic [1:0] cc_new;

    hfp_sign_edit u_sign (
        .op       (op),
        .sign_in  (src[SIGN_POS]),
        .sign_out (new_sign),
        .sets_cc  (sets_cc)
    );

    hfp_cc_gen u_ccg (
        .sign    (new_sign),
        .frac    (src[FRAC_TOP:0]),
        .is_long (is_long),
        .cc      (cc_new)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.cc_we = 1'b0;
        if (in_valid) begin
            st_d.done = 1'b1;
            if (is_long) begin
                st_d.res = {new_sign, src[SIGN_POS-1:0]};
            end else begin
                st_d.res = {new_sign, src[SIGN_POS-1:HALF_W], dst_old[HALF_W-1:0]};
            end
            if (sets_cc) begin
                st_d.cc    = cc_new;
                st_d.cc_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;
    assign cc     = st_q.cc;
    assign cc_we  = st_q.cc_we;
    assign done   = st_q.done;

    AST_CHAR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> result[SIGN_POS-1:SIGN_POS-CHAR_W] == $past(src[SIGN_POS-1:SIGN_POS-CHAR_W])); // R1
    AST_SHORT_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !is_long) |-> result[HALF_W-1:0] == $past(dst_old[HALF_W-1:0])); // R2
    AST_LONG_LOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && is_long) |-> result[HALF_W-1:0] == $past(src[HALF_W-1:0])); // R3
    AST_CC_VALUE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> cc != 2'd3); // R5
    AST_LOAD_NO_CC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && (op == OP_LOAD)) |-> !cc_we); // R6
    AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |-> $stable(cc)); // R6
    AST_POS_NEVER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && (op == OP_POS)) |-> cc != CC_NEG); // R7
    AST_NEG_NEVER_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && (op == OP_NEG)) |-> cc != CC_POS); // R7
    AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done == $past(in_valid)); // R8
    AST_WE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> done); // R8
endmodule

// File: tb/hfp_signload_bench.sv
module hfp_signload_bench;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        is_long = 1'b0;
    logic [63:0] src = '0;
    logic [63:0] dst_old = '0;
    logic [63:0] result;
    logic [1:0]  cc;
    logic        cc_we;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hfp_signload u_hfp_signload (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .is_long(is_long), .src(src), .dst_old(dst_old),
        .result(result), .cc(cc), .cc_we(cc_we), .done(done)
    );

    // {op, is_long, src, dst_old, exp_result, exp_cc, exp_we}
    typedef struct packed {
        logic [2:0]  op;
        logic        lng;
        logic [63:0] s;
        logic [63:0] d;
        logic [63:0] r;
        logic [1:0]  c;
        logic        w;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{3'd1, 1'b1, 64'h4110_0000_0000_0000, 64'h0, 64'h4110_0000_0000_0000, 2'd2, 1'b1},
        '{3'd1, 1'b1, 64'hC110_0000_0000_0000, 64'h0, 64'hC110_0000_0000_0000, 2'd1, 1'b1},
        '{3'd1, 1'b1, 64'hC100_0000_0000_0000, 64'h0, 64'hC100_0000_0000_0000, 2'd0, 1'b1},
        '{3'd2, 1'b1, 64'h4200_0000_0000_0001, 64'h0, 64'hC200_0000_0000_0001, 2'd1, 1'b1},
        '{3'd3, 1'b1, 64'hBF12_3456_789A_BCDE, 64'h0, 64'h3F12_3456_789A_BCDE, 2'd2, 1'b1},
        '{3'd4, 1'b1, 64'h3F12_3456_789A_BCDE, 64'h0, 64'hBF12_3456_789A_BCDE, 2'd1, 1'b1},
        '{3'd4, 1'b1, 64'h0000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000, 2'd0, 1'b1},
        '{3'd3, 1'b0, 64'hC100_0000_FFFF_FFFF, 64'h1111_1111_2222_2222, 64'h4100_0000_2222_2222, 2'd0, 1'b1},
        '{3'd2, 1'b0, 64'h4A12_3456_0000_0000, 64'hAAAA_AAAA_5555_5555, 64'hCA12_3456_5555_5555, 2'd1, 1'b1},
        '{3'd0, 1'b0, 64'hC555_5555_0123_4567, 64'h0000_0000_89AB_CDEF, 64'hC555_5555_89AB_CDEF, 2'd1, 1'b0},
        '{3'd0, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h0, 64'h0123_4567_89AB_CDEF, 2'd1, 1'b0},
        '{3'd7, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b0},
        '{3'd1, 1'b0, 64'h0000_0001_0000_0000, 64'h0, 64'h0000_0001_0000_0000, 2'd2, 1'b1},
        '{3'd4, 1'b0, 64'h00FF_FFFF_0000_0000, 64'h0, 64'h80FF_FFFF_0000_0000, 2'd1, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 result", result, 64'h0);
        chk("R9 cc", {62'h0, cc}, 64'h0);
        chk("R9 done/we", {62'h0, done, cc_we}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            op = VEC[i].op; is_long = VEC[i].lng;
            src = VEC[i].s; dst_old = VEC[i].d;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R1/R2/R3/R4 result v%0d", i), result, VEC[i].r);
            chk($sformatf("R5/R7 cc v%0d", i), {62'h0, cc}, {62'h0, VEC[i].c});
            chk($sformatf("R6 cc_we v%0d", i), {63'h0, cc_we}, {63'h0, VEC[i].w});
            chk($sformatf("R8 done v%0d", i), {63'h0, done}, 64'h1);
        end

        // R8: idle cycle holds result and cc, strobes low
        held = result;
        src = 64'hDEAD_BEEF_DEAD_BEEF; op = 3'd2; is_long = 1'b1;
        @(negedge clk);
        chk("R8 idle result hold", result, held);
        chk("R8 idle cc hold", {62'h0, cc}, 64'h1);
        chk("R8 idle done low", {62'h0, done, cc_we}, 64'h0);

        // R2: short src low half ignored, two different low halves same output
        op = 3'd1; is_long = 1'b0; dst_old = 64'h0;
        src = 64'h4100_0000_1234_5678; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 low src ignored result", result, 64'h4100_0000_0000_0000);
        chk("R2 low src ignored cc", {62'h0, cc}, 64'h0);

        // R9: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset result", result, 64'h0);
        chk("R9 reset cc/done", {61'h0, cc, done}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule